// File: doc/BRIEF.md
# Doubleword Write Combiner for a Flash Staging Buffer

This block stages data for a flash array whose native storage unit is a 64-bit doubleword, while the system bus that fills it carries only 32 bits per transfer. A bus master writes each doubleword as two aligned 32-bit words. The first word goes to the doubleword base address and the second to base+4. The block holds the first word aside until the matching second word arrives. It then merges the assembled doubleword into one of its entries.

Merging can only clear bits: the stored value becomes the bitwise AND of the old value and the new doubleword. A separate clear command returns every entry to all ones. That command is the only way to set bits again. Both a doubleword merge and a clear hold the bus off for a fixed number of wait states. Errors are reported for write shapes the buffer does not accept, and for bus reads. A programming sequencer on the flash side reads entries through an independent combinational read port.

Top module: `pgbuf_combiner`

## Requirements
- R1: After reset every entry reads all ones, no low word is pending, `bus_ready_o` is high, and `busy_o` and `bus_err_o` are low.
- R2: An accepted word write with address bit 2 clear (a low word) is held pending. It changes no entry and does not lower `bus_ready_o`.
- R3: An accepted word write with address bit 2 set, whose index (address bits 7:3) equals the pending low word's index, builds a doubleword. The low word goes in bits 31:0 and the new word in bits 63:32. This write consumes the pending low word.
- R4: A built doubleword is merged by AND with the stored entry, so bits only go from one to zero. For example, writing AAAAAAAA over a stored 00000000 leaves 00000000.
- R5: A doubleword merge holds `busy_o` high and `bus_ready_o` low for exactly WAIT_CYC (4) cycles after the accepting edge. The merged entry is visible on the read port once `busy_o` falls, and not before.
- R6: A high-word write with no pending low word, or with a pending low word of another index, is discarded and flagged as an error. Any pending low word is kept.
- R7: A low-word write while a low word is already pending replaces the pending word and index. Nothing is merged.
- R8: A write whose size is not a word (`bus_size_i` 00 = byte, 01 = halfword, 10 = word) or whose address bits 1:0 are non-zero is flagged as an error. It changes no entry and leaves the pending low word intact.
- R9: A bus read is flagged as an error, and `bus_rdata_o` never carries buffer contents (it reads zero).
- R10: A clear command sets every entry to all ones and drops the pending low word. It holds `busy_o` high for the same WAIT_CYC cycles as a merge.
- R11: When `clear_i` and a bus request are both present in an idle cycle, the clear is taken and the bus request waits. `clear_i` has no effect while `busy_o` is high.
- R12: `bus_err_o` is a one-cycle pulse in the cycle right after the accepting edge of the faulty access.
- R13: `rd_data_o` shows the entry selected by `rd_idx_i` combinationally, independent of bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access request, held until accepted |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| bus_addr_i | input | 8 | Byte offset within the buffer |
| bus_wdata_i | input | 32 | Write data |
| bus_ready_o | output | 1 | Request accepted on the rising edge where this is high |
| bus_rdata_o | output | 32 | Read data, always zero |
| bus_err_o | output | 1 | Error response for the access accepted on the previous edge |
| clear_i | input | 1 | Clear command, taken in an idle cycle |
| busy_o | output | 1 | Merge or clear in progress, bus stalled |
| rd_idx_i | input | 5 | Flash-side entry index |
| rd_data_o | output | 64 | Flash-side entry contents |

## Verification
A clear command and a bus write can arrive in the same idle cycle. The bench raises `clear_i` together with a pending low-word request on one falling edge. It checks that `bus_ready_o` is low in that cycle and that the stall that follows lasts the clear length. The held request must be taken only once the stall ends, and its low word must survive, since it arrived after the clear dropped the old pending word. A second collision pulses `clear_i` during a merge stall. The bench confirms that the merged entry keeps its cleared bits and that no extra stall follows.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } bus_size_e;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_LOW,
    ACC_HIGH,
    ACC_BAD
  } acc_kind_e;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_WR,
    OP_CLR
  } op_e;

endpackage

// File: rtl/pgbuf_decode.sv
module pgbuf_decode
  import pgbuf_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned LSB_W  = 2,
  localparam int unsigned ADDR_W = IDX_W + LSB_W + 1
) (
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);

  logic shape_ok;

  assign shape_ok = we_i && (size_i == SZ_WORD) && (addr_i[LSB_W-1:0] == '0);
  assign idx_o    = addr_i[ADDR_W-1:LSB_W+1];

  always_comb begin
    if (!acc_i)              kind_o = ACC_NONE;
    else if (!shape_ok)      kind_o = ACC_BAD;
    else if (addr_i[LSB_W])  kind_o = ACC_HIGH;
    else                     kind_o = ACC_LOW;
  end

endmodule

// File: rtl/pgbuf_pair.sv
module pgbuf_pair #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned BUS_W = 32,
  localparam int unsigned DW_W = 2 * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lo_i,
  input  logic             hi_i,
  input  logic             drop_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             match_o,
  output logic [DW_W-1:0]  dword_o
);

  logic             vld_q;
  logic [IDX_W-1:0] idx_q;
  logic [BUS_W-1:0] lo_q;

  assign match_o = vld_q && (idx_q == idx_i);
  assign dword_o = {wdata_i, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      idx_q <= '0;
      lo_q  <= '0;
    end else if (drop_i) begin
      vld_q <= 1'b0;
    end else if (lo_i) begin
      vld_q <= 1'b1;
      idx_q <= idx_i;
      lo_q  <= wdata_i;
    end else if (hi_i && match_o) begin
      vld_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq
  import pgbuf_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 4,
  localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_wr_i,
  input  logic start_clr_i,
  output logic busy_o,
  output logic wr_apply_o,
  output logic clr_apply_o
);

  op_e              op_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last        = (cnt_q == CNT_W'(1));
  assign busy_o      = (op_q != OP_IDLE);
  assign wr_apply_o  = (op_q == OP_WR)  && last;
  assign clr_apply_o = (op_q == OP_CLR) && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else if (op_q == OP_IDLE) begin
      if (start_clr_i) begin
        op_q  <= OP_CLR;
        cnt_q <= CNT_W'(WAIT_CYC);
      end else if (start_wr_i) begin
        op_q  <= OP_WR;
        cnt_q <= CNT_W'(WAIT_CYC);
      end
    end else if (last) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW_W  = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DW_W-1:0]  wr_data_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW_W-1:0]  rd_data_o
);

  logic [DW_W-1:0] rows [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DW_W-1:0] ent_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      ent_q <= '1;
      else if (clr_i)                                   ent_q <= '1;
      else if (wr_en_i && (wr_idx_i == IDX_W'(i)))      ent_q <= ent_q & wr_data_i;
    end

    assign rows[i] = ent_q;
  end

  assign rd_data_o = rows[rd_idx_i];

endmodule

// File: rtl/pgbuf_combiner.sv
module pgbuf_combiner
  import pgbuf_pkg::*;
#(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned WAIT_CYC = 4,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned DW_W   = 2 * BUS_W,
  localparam int unsigned LSB_W  = $clog2(BUS_W / 8),
  localparam int unsigned ADDR_W = IDX_W + LSB_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_size_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic              bus_ready_o,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              bus_err_o,
  input  logic              clear_i,
  output logic              busy_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DW_W-1:0]   rd_data_o
);

  acc_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic             acc, match, start_wr, start_clr;
  logic             wr_apply, clr_apply, err_q;
  logic [DW_W-1:0]  dword, cmt_data_q;
  logic [IDX_W-1:0] cmt_idx_q;

  // clear wins over a bus request in the same idle cycle
  assign bus_ready_o = !busy_o && !clear_i;
  assign acc         = bus_req_i && bus_ready_o;
  assign start_clr   = clear_i && !busy_o;
  assign start_wr    = (kind == ACC_HIGH) && match;
  assign bus_rdata_o = '0;
  assign bus_err_o   = err_q;

  pgbuf_decode #(.IDX_W(IDX_W), .LSB_W(LSB_W)) u_dec (
    .acc_i  (acc),
    .we_i   (bus_we_i),
    .size_i (bus_size_i),
    .addr_i (bus_addr_i),
    .kind_o (kind),
    .idx_o  (idx)
  );

  pgbuf_pair #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_pair (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_i    (kind == ACC_LOW),
    .hi_i    (kind == ACC_HIGH),
    .drop_i  (clr_apply),
    .idx_i   (idx),
    .wdata_i (bus_wdata_i),
    .match_o (match),
    .dword_o (dword)
  );

  pgbuf_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_wr_i  (start_wr),
    .start_clr_i (start_clr),
    .busy_o      (busy_o),
    .wr_apply_o  (wr_apply),
    .clr_apply_o (clr_apply)
  );

  pgbuf_store #(.DEPTH(DEPTH), .DW_W(DW_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_apply),
    .wr_idx_i  (cmt_idx_q),
    .wr_data_i (cmt_data_q),
    .clr_i     (clr_apply),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmt_idx_q  <= '0;
      cmt_data_q <= '1;
      err_q      <= 1'b0;
    end else begin
      err_q <= (kind == ACC_BAD) || ((kind == ACC_HIGH) && !match);
      if (start_wr) begin
        cmt_idx_q  <= idx;
        cmt_data_q <= dword;
      end
    end
  end

endmodule

// File: rtl/pgbuf_combiner_chk.sv
module pgbuf_combiner_chk #(
  parameter int unsigned WAIT_CYC = 4,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned DW_W     = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_req_i,
  input logic             bus_ready_o,
  input logic             bus_err_o,
  input logic             clear_i,
  input logic             busy_o,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic [DW_W-1:0]  rd_data_o,
  input logic             wr_apply,
  input logic             clr_apply
);

  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  p_stall_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == WAIT_CYC);

  p_only_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rd_idx_i) && !$past(clr_apply)) |-> ((rd_data_o & ~$past(rd_data_o)) == '0));

  p_store_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rd_idx_i) && !$past(wr_apply) && !$past(clr_apply)) |-> $stable(rd_data_o));

  p_err_after_acc_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> $past(bus_req_i && bus_ready_o));

  p_clear_starts_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !busy_o) |=> busy_o);

  p_clear_ones_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_apply) |-> (rd_data_o == '1));

endmodule

bind pgbuf_combiner pgbuf_combiner_chk #(
  .WAIT_CYC (WAIT_CYC),
  .IDX_W    (IDX_W),
  .DW_W     (DW_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_ready_o (bus_ready_o),
  .bus_err_o   (bus_err_o),
  .clear_i     (clear_i),
  .busy_o      (busy_o),
  .rd_idx_i    (rd_idx_i),
  .rd_data_o   (rd_data_o),
  .wr_apply    (wr_apply),
  .clr_apply   (clr_apply)
);

// File: tb/pgbuf_combiner_test.sv
`timescale 1ns/1ps
module pgbuf_combiner_test;

  localparam int DEPTH = 32;
  localparam int WAITC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, clr = 1'b0;
  logic [1:0]  sz = 2'b10;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [4:0]  rd_idx = '0;
  logic        ready, err, busy;
  logic [31:0] rdata;
  logic [63:0] rd_data;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [63:0] exp_mem [DEPTH];

  always #10 clk = ~clk;

  pgbuf_combiner uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_size_i(sz),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_ready_o(ready), .bus_rdata_o(rdata),
    .bus_err_o(err), .clear_i(clr), .busy_o(busy), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  // returns at the falling edge after the accepting edge
  task automatic bus_op(input logic w, input logic [7:0] a, input logic [1:0] s,
                        input logic [31:0] d, output logic e, output logic [31:0] rv);
    @(negedge clk);
    req = 1; we = w; addr = a; sz = s; wdata = d;
    #1;
    while (!ready) @(negedge clk);
    rv = rdata;
    @(negedge clk);
    req = 0;
    e = err;
  endtask

  task automatic stall_len(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = 5'(i);
      #1;
      chk(tag, rd_data, exp_mem[i]);
    end
  endtask

  task automatic wr_pair(input int idx, input logic [31:0] lo, input logic [31:0] hi);
    logic e; logic [31:0] rv; int n;
    bus_op(1, {5'(idx), 3'b000}, 2'b10, lo, e, rv);
    chk("R2 low word no error", 64'(e), 0);
    chk("R2 low word no stall", 64'(busy), 0);
    bus_op(1, {5'(idx), 3'b100}, 2'b10, hi, e, rv);
    chk("R3 high word no error", 64'(e), 0);
    stall_len(n);
    chk("R5 merge stall length", 64'(n), WAITC);
    exp_mem[idx] = exp_mem[idx] & {hi, lo};
  endtask

  task automatic do_clear();
    int n;
    @(negedge clk);
    clr = 1;
    while (busy) @(negedge clk);
    @(negedge clk);
    clr = 0;
    stall_len(n);
    chk("R10 clear stall length", 64'(n), WAITC);
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '1;
  endtask

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic e; logic [31:0] rv; int n;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", 64'(ready), 1);
    chk("R1 busy after reset", 64'(busy), 0);
    chk("R1 err after reset", 64'(err), 0);
    check_all("R1 entries all ones");
    rd_idx = 5'd7; #1;
    chk("R13 read port ignores idle bus", rd_data, '1);

    // R3 R4 two full sweeps, AND accumulation
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < DEPTH; i++)
        wr_pair(i, ~((32'(i) * 32'h0102_0409) << p), ~((32'(i + 1) * 32'h1F03_0507) >> p));
      check_all("R4 sweep merge");
    end

    // R4 AAAAAAAA over zero stays zero
    wr_pair(9, 32'h0, 32'h0);
    wr_pair(9, 32'hAAAA_AAAA, 32'hAAAA_AAAA);
    rd_idx = 5'd9; #1;
    chk("R4 no bit set from zero", rd_data, 64'h0);

    do_clear();
    check_all("R10 clear restores ones");

    // R6 orphan high word, nothing pending
    bus_op(1, {5'd3, 3'b100}, 2'b10, 32'h0, e, rv);
    chk("R6 orphan high err", 64'(e), 1);
    @(negedge clk);
    chk("R12 err is one pulse", 64'(err), 0);
    chk("R6 orphan no stall", 64'(busy), 0);
    rd_idx = 5'd3; #1;
    chk("R6 orphan discarded", rd_data, '1);

    // R6 mismatched index keeps pending
    bus_op(1, {5'd4, 3'b000}, 2'b10, 32'h1234_5678, e, rv);
    bus_op(1, {5'd5, 3'b100}, 2'b10, 32'h0, e, rv);
    chk("R6 mismatched high err", 64'(e), 1);
    rd_idx = 5'd5; #1;
    chk("R6 mismatched discarded", rd_data, '1);
    // R8 byte / halfword / misaligned keep pending
    bus_op(1, {5'd4, 3'b100}, 2'b00, 32'h0, e, rv);
    chk("R8 byte write err", 64'(e), 1);
    bus_op(1, {5'd4, 3'b100}, 2'b01, 32'h0, e, rv);
    chk("R8 halfword write err", 64'(e), 1);
    bus_op(1, {5'd4, 3'b110}, 2'b10, 32'h0, e, rv);
    chk("R8 misaligned write err", 64'(e), 1);
    rd_idx = 5'd4; #1;
    chk("R8 bad writes ignored", rd_data, '1);
    // R9 read
    bus_op(0, {5'd4, 3'b000}, 2'b10, 32'h0, e, rv);
    chk("R9 read err", 64'(e), 1);
    chk("R9 read data zero", 64'(rv), 0);
    bus_op(1, {5'd4, 3'b100}, 2'b10, 32'h0F0F_F0F0, e, rv);
    chk("R6 pending kept then pairs", 64'(e), 0);
    stall_len(n);
    rd_idx = 5'd4; #1;
    chk("R3 low in bits 31:0", rd_data, 64'h0F0F_F0F0_1234_5678);
    exp_mem[4] = 64'h0F0F_F0F0_1234_5678;

    // R7 low word replaced
    bus_op(1, {5'd6, 3'b000}, 2'b10, 32'h0000_FFFF, e, rv);
    chk("R7 first low no stall", 64'(busy), 0);
    bus_op(1, {5'd2, 3'b000}, 2'b10, 32'hFFFF_0000, e, rv);
    rd_idx = 5'd6; #1;
    chk("R7 replace merges nothing", rd_data, '1);
    bus_op(1, {5'd6, 3'b100}, 2'b10, 32'h0, e, rv);
    chk("R7 old index now orphan", 64'(e), 1);
    bus_op(1, {5'd2, 3'b100}, 2'b10, 32'h00FF_00FF, e, rv);
    chk("R7 new index pairs", 64'(e), 0);
    // R5 entry not yet visible during stall
    rd_idx = 5'd2; #1;
    chk("R5 not visible during stall", rd_data, '1);
    // R11 clear during busy ignored
    clr = 1;
    @(negedge clk);
    clr = 0;
    stall_len(n);
    chk("R11 no extra stall", 64'(n), WAITC - 1);
    rd_idx = 5'd2; #1;
    chk("R11 clear while busy ignored", rd_data, 64'h00FF_00FF_FFFF_0000);
    exp_mem[2] = 64'h00FF_00FF_FFFF_0000;
    check_all("R5 only target entry changed");

    // R10 clear drops pending
    bus_op(1, {5'd5, 3'b000}, 2'b10, 32'h0, e, rv);
    do_clear();
    bus_op(1, {5'd5, 3'b100}, 2'b10, 32'h0, e, rv);
    chk("R10 pending dropped by clear", 64'(e), 1);
    rd_idx = 5'd5; #1;
    chk("R10 entry stays ones", rd_data, '1);

    // R11 clear and bus request in the same idle cycle
    bus_op(1, {5'd8, 3'b000}, 2'b10, 32'h0, e, rv);
    @(negedge clk);
    req = 1; we = 1; sz = 2'b10; addr = {5'd8, 3'b000}; wdata = 32'hCAFE_0001;
    clr = 1;
    #1;
    chk("R11 clear blocks request", 64'(ready), 0);
    @(negedge clk);
    clr = 0;
    chk("R11 clear taken", 64'(busy), 1);
    n = 0;
    while (!ready) begin n++; @(negedge clk); #1; end
    chk("R11 request waits clear stall", 64'(n), WAITC);
    @(negedge clk);
    req = 0;
    chk("R11 held low accepted", 64'(err), 0);
    bus_op(1, {5'd8, 3'b100}, 2'b10, 32'hBEEF_0002, e, rv);
    chk("R11 later low pairs", 64'(e), 0);
    stall_len(n);
    rd_idx = 5'd8; #1;
    chk("R11 doubleword after clear", rd_data, 64'hBEEF_0002_CAFE_0001);

    summary();
  end

endmodule